// File: doc/BRIEF.md
# Mixed-Width Two-Way Dot-Product Accumulator

This block is a two-stage pipelined integer datapath. It takes one word that packs two 16-bit elements, a second word that packs four 8-bit elements, and a 32-bit addend. Two of the four bytes are selected by a half-select bit. Each byte is multiplied by one of the 16-bit elements. The two products are added together, and that sum is added to the addend to form a 32-bit result.

Each operand word has its own signedness control. That control decides whether the word's elements are sign-extended or zero-extended before they are multiplied.

Operands enter through a valid/ready handshake and results leave through another. When the consumer stalls, the whole pipeline stops and nothing is lost.

Top module: `dot2_mix_acc`

## Requirements
- R1: When `a_signed` is 1, each 16-bit element of `a_word` is sign-extended before it is multiplied. When it is 0, each element is zero-extended. Element i of `a_word` sits at bits [16i+15:16i].
- R2: When `b_signed` is 1, each byte of `b_word` is sign-extended before it is multiplied. When it is 0, each byte is zero-extended. Byte j of `b_word` sits at bits [8j+7:8j].
- R3: When `half_sel` is 0, the products use bytes 2 and 3 of `b_word`. When `half_sel` is 1, they use bytes 0 and 1.
- R4: Element 0 of `a_word` is multiplied by the lower-indexed selected byte. Element 1 is multiplied by the higher-indexed one.
- R5: `result` equals `addend` plus both products, wrapped modulo 2^32. There is no saturation. The signedness of the addend does not change the 32-bit result.
- R6: The accept cycle is a cycle in which `in_valid` and `in_ready` are both high. When `out_ready` stays high, `out_valid` is low in the cycle after the accept cycle and high in the second cycle after it.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `result` holds its value into the next cycle. Results leave in the order their operands were accepted, and none is lost.
- R8: `in_ready` is low only when two accepted operand sets are still waiting to leave and `out_ready` is low. In particular, `in_ready` is high whenever `out_valid` is low.
- R9: A synchronous active-high `rst` empties both pipeline stages. In the cycle after reset is released, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand set present |
| in_ready | output | 1 | Block can take an operand set this cycle |
| a_word | input | 32 | Two packed 16-bit elements, element 0 in the low half |
| b_word | input | 32 | Four packed bytes, byte 0 in the low byte |
| addend | input | 32 | Value the dot product is added to |
| a_signed | input | 1 | 1: elements of `a_word` are signed |
| b_signed | input | 1 | 1: bytes of `b_word` are signed |
| half_sel | input | 1 | 0: bytes 2 and 3 are used, 1: bytes 0 and 1 are used |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| result | output | 32 | Wrapped 32-bit dot-product accumulation |

## Verification
A wrong extension, byte choice or pairing shows at the ports as a wrong `result`. It appears two cycles after the operand set that exposes it is accepted, so each result can be traced back to one input. A lost or duplicated stage-valid flag shows up as a result that is missing, repeated or out of order in the output stream. It also shows up as `in_ready` disagreeing with the count of operand sets still in flight, and that disagreement is visible in the very cycle it occurs. A stage that moves while stalled changes `result` between two stalled cycles, which is visible one cycle later.

// File: rtl/dot2_pkg.sv
package dot2_pkg;

    // Default geometry of the datapath
    localparam int unsigned DFLT_A_EW   = 16;
    localparam int unsigned DFLT_B_EW   = 8;
    localparam int unsigned DFLT_NA     = 2;
    localparam int unsigned DFLT_ACC_W  = 32;

    // Half-select encoding: which pair of bytes feeds the multipliers
    typedef enum logic {
        HALF_UPPER = 1'b0,   // bytes NA .. 2*NA-1
        HALF_LOWER = 1'b1    // bytes 0 .. NA-1
    } half_sel_e;

    // Width of one extended product: (a_ew+1) x (b_ew+1) signed
    function automatic int unsigned prod_width(int unsigned a_ew, int unsigned b_ew);
        return a_ew + b_ew + 2;
    endfunction

    // Width of a sum of n products without loss
    function automatic int unsigned sum_width(int unsigned pw, int unsigned n);
        return pw + $clog2(n);
    endfunction

    // Byte index feeding lane k for a given half select
    function automatic int unsigned pick_index(half_sel_e hs, int unsigned k, int unsigned na);
        return (hs == HALF_LOWER) ? k : k + na;
    endfunction

endpackage

// File: rtl/dot2_byte_pick.sv
module dot2_byte_pick
    import dot2_pkg::*;
#(
    parameter int unsigned B_EW = DFLT_B_EW,
    parameter int unsigned NA   = DFLT_NA,
    localparam int unsigned NB  = 2 * NA
) (
    input  logic [NB-1:0][B_EW-1:0] b_lanes,
    input  half_sel_e               hs,
    output logic [NA-1:0][B_EW-1:0] picked
);

    // One selector per multiplier lane
    for (genvar k = 0; k < NA; k++) begin : g_pick
        always_comb begin
            picked[k] = b_lanes[pick_index(hs, k, NA)];
        end
    end

endmodule

// File: rtl/dot2_lane_mult.sv
module dot2_lane_mult
    import dot2_pkg::*;
#(
    parameter int unsigned A_EW = DFLT_A_EW,
    parameter int unsigned B_EW = DFLT_B_EW,
    localparam int unsigned PW  = prod_width(A_EW, B_EW)
) (
    input  logic                 [A_EW-1:0] a_elem,
    input  logic                 [B_EW-1:0] b_elem,
    input  logic                            a_sgn,
    input  logic                            b_sgn,
    output logic signed          [PW-1:0]   prod
);

    logic signed [A_EW:0] a_ext;
    logic signed [B_EW:0] b_ext;

    // One guard bit per operand carries the sign (or a zero for unsigned)
    always_comb begin
        a_ext = {a_sgn & a_elem[A_EW-1], a_elem};
        b_ext = {b_sgn & b_elem[B_EW-1], b_elem};
        prod  = PW'(a_ext) * PW'(b_ext);
    end

endmodule

// File: rtl/dot2_reduce_add.sv
module dot2_reduce_add
    import dot2_pkg::*;
#(
    parameter int unsigned PW    = prod_width(DFLT_A_EW, DFLT_B_EW),
    parameter int unsigned NA    = DFLT_NA,
    parameter int unsigned ACC_W = DFLT_ACC_W,
    localparam int unsigned SW   = sum_width(PW, NA)
) (
    input  logic [NA-1:0][PW-1:0] prods,
    input  logic [ACC_W-1:0]      addend,
    output logic [ACC_W-1:0]      total
);

    logic signed [SW-1:0]    psum;
    logic        [ACC_W-1:0] psum_x;

    always_comb begin
        psum = '0;
        for (int i = 0; i < NA; i++) begin
            psum = psum + SW'($signed(prods[i]));
        end
        // Sign-extend the exact product sum, then wrap into the accumulator
        psum_x = ACC_W'(psum);
        total  = addend + psum_x;
    end

endmodule

// File: rtl/dot2_mix_acc.sv
module dot2_mix_acc
    import dot2_pkg::*;
#(
    parameter int unsigned A_EW  = DFLT_A_EW,
    parameter int unsigned B_EW  = DFLT_B_EW,
    parameter int unsigned NA    = DFLT_NA,
    parameter int unsigned ACC_W = DFLT_ACC_W,
    localparam int unsigned NB   = 2 * NA,
    localparam int unsigned AW   = NA * A_EW,
    localparam int unsigned BW   = NB * B_EW,
    localparam int unsigned PW   = prod_width(A_EW, B_EW)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [AW-1:0]    a_word,
    input  logic [BW-1:0]    b_word,
    input  logic [ACC_W-1:0] addend,
    input  logic             a_signed,
    input  logic             b_signed,
    input  logic             half_sel,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [ACC_W-1:0] result
);

    typedef struct packed {
        logic                 vld;
        logic [NA-1:0][PW-1:0] prods;
        logic [ACC_W-1:0]     addend;
    } mul_stage_t;

    typedef struct packed {
        logic             vld;
        logic [ACC_W-1:0] total;
    } acc_stage_t;

    logic [NA-1:0][A_EW-1:0] a_lanes;
    logic [NB-1:0][B_EW-1:0] b_lanes;
    logic [NA-1:0][B_EW-1:0] b_sel;
    logic [NA-1:0][PW-1:0]   prod_d;
    logic [ACC_W-1:0]        total_d;
    half_sel_e               hs;

    mul_stage_t s1_q;
    acc_stage_t s2_q;
    logic       adv2;

    always_comb begin
        a_lanes = a_word;
        b_lanes = b_word;
        hs      = half_sel_e'(half_sel);
    end

    dot2_byte_pick #(.B_EW(B_EW), .NA(NA)) u_pick (
        .b_lanes (b_lanes),
        .hs      (hs),
        .picked  (b_sel)
    );

    for (genvar k = 0; k < NA; k++) begin : g_lane
        logic signed [PW-1:0] p;
        dot2_lane_mult #(.A_EW(A_EW), .B_EW(B_EW)) u_mul (
            .a_elem (a_lanes[k]),
            .b_elem (b_sel[k]),
            .a_sgn  (a_signed),
            .b_sgn  (b_signed),
            .prod   (p)
        );
        always_comb prod_d[k] = p;
    end

    dot2_reduce_add #(.PW(PW), .NA(NA), .ACC_W(ACC_W)) u_sum (
        .prods  (s1_q.prods),
        .addend (s1_q.addend),
        .total  (total_d)
    );

    // Stage 2 moves when it is empty or its result is being taken
    always_comb begin
        adv2     = out_ready | ~s2_q.vld;
        in_ready = ~s1_q.vld | adv2;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q.vld <= 1'b0;
            s2_q.vld <= 1'b0;
        end else begin
            if (in_ready) s1_q.vld <= in_valid;
            if (adv2)     s2_q.vld <= s1_q.vld;
        end
    end

    always_ff @(posedge clk) begin
        if (in_ready && in_valid) begin
            s1_q.prods  <= prod_d;
            s1_q.addend <= addend;
        end
        if (adv2 && s1_q.vld) begin
            s2_q.total <= total_d;
        end
    end

    always_comb begin
        out_valid = s2_q.vld;
        result    = s2_q.total;
    end

endmodule

// File: rtl/dot2_mix_acc_chk.sv
module dot2_mix_acc_chk #(
    parameter int unsigned ACC_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [ACC_W-1:0] result
);

    // R9: pipeline is empty right after reset
    a_r9_reset_empty: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !out_valid);

    // R7: a stalled result is held
    a_r7_stall_hold: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(result)));

    // R8: an empty output stage never blocks the input
    a_r8_ready_when_empty: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> in_ready);

    // R8: input blocked only under downstream backpressure
    a_r8_block_cause: assert property (@(posedge clk) disable iff (rst)
        !in_ready |-> (out_valid && !out_ready));

    // R6: accepted operands reach the output two cycles later when not stalled
    a_r6_latency: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) ##1 out_ready |=> out_valid);

endmodule

bind dot2_mix_acc dot2_mix_acc_chk #(.ACC_W(ACC_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .result    (result)
);

// File: tb/dot2_mix_acc_bench.sv
`timescale 1ns/1ps
module dot2_mix_acc_bench;

    localparam int N_ITEMS = 768;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] a_word = '0;
    logic [31:0] b_word = '0;
    logic [31:0] addend = '0;
    logic        a_signed = 1'b0;
    logic        b_signed = 1'b0;
    logic        half_sel = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] result;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #2 clk = ~clk;   // 250 MHz

    dot2_mix_acc u_dot2_mix_acc (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .a_word(a_word), .b_word(b_word), .addend(addend),
        .a_signed(a_signed), .b_signed(b_signed), .half_sel(half_sel),
        .out_valid(out_valid), .out_ready(out_ready), .result(result)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // Reference model built from the requirements
    function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] b,
                                          input logic [31:0] c, input bit as, input bit bs,
                                          input bit hs);
        longint acc = longint'(c);
        for (int k = 0; k < 2; k++) begin
            logic [15:0] ae = a[16*k +: 16];
            int          j  = hs ? k : k + 2;
            logic [7:0]  be = b[8*j +: 8];
            longint av = as ? longint'($signed(ae)) : longint'(ae);
            longint bv = bs ? longint'($signed(be)) : longint'(be);
            acc += av * bv;
        end
        return acc[31:0];
    endfunction

    logic [15:0] av_tab [6] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h1234};
    logic [7:0]  bv_tab [4] = '{8'h00, 8'h7F, 8'h80, 8'hFF};
    logic [31:0] cv_tab [4] = '{32'h0000_0000, 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF};

    logic [31:0] st_a [N_ITEMS];
    logic [31:0] st_b [N_ITEMS];
    logic [31:0] st_c [N_ITEMS];
    logic [2:0]  st_m [N_ITEMS];
    logic [31:0] st_e [N_ITEMS];
    logic [31:0] exp_q [$];

    initial begin : watchdog
        int cnt = 0;
        while (!done && cnt < 100000) begin
            @(posedge clk);
            cnt++;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete actual=%0d expected<100000", cnt);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] e;
        int idx, inflight, cyc, win;
        bit prev_stall;
        logic [31:0] prev_res;

        // Build the sweep: every control combination over corner operands
        for (int m = 0; m < 8; m++) begin
            for (int ia = 0; ia < 6; ia++) begin
                for (int ib = 0; ib < 16; ib++) begin
                    int n = m * 96 + ia * 16 + ib;
                    st_a[n] = {av_tab[(ia + 2) % 6], av_tab[ia]};
                    st_b[n] = {bv_tab[(ib / 4 + 2) % 4], bv_tab[(ib + 1) % 4],
                               bv_tab[ib / 4], bv_tab[ib % 4]};
                    st_c[n] = cv_tab[(ia + ib) % 4] ^ (32'(n) << 5);
                    st_m[n] = 3'(m);
                    st_e[n] = model(st_a[n], st_b[n], st_c[n], m[0], m[1], m[2]);
                end
            end
        end

        // R9: reset state
        repeat (3) @(negedge clk);
        #1;
        chk(!out_valid, "R9 out_valid during reset", {31'b0, out_valid}, 32'd0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        chk(!out_valid, "R9 out_valid after reset", {31'b0, out_valid}, 32'd0);
        chk(in_ready,   "R9 in_ready after reset",  {31'b0, in_ready},  32'd1);

        // R6: latency of one operand set with no backpressure
        @(negedge clk);
        a_word = 32'hFFFE_0003; b_word = 32'h0405_FD02; addend = 32'd100;
        a_signed = 1'b1; b_signed = 1'b1; half_sel = 1'b1; in_valid = 1'b1; out_ready = 1'b1;
        #1;
        chk(in_ready, "R6 accept", {31'b0, in_ready}, 32'd1);
        e = model(a_word, b_word, addend, 1'b1, 1'b1, 1'b1);
        @(negedge clk);
        in_valid = 1'b0;
        #1;
        chk(!out_valid, "R6 not valid one cycle after accept", {31'b0, out_valid}, 32'd0);
        @(negedge clk);
        #1;
        chk(out_valid, "R6 valid two cycles after accept", {31'b0, out_valid}, 32'd1);
        chk(result == e, "R6/R5 latency-test value", result, e);
        @(negedge clk);
        #1;
        chk(!out_valid, "R6 single result drained", {31'b0, out_valid}, 32'd0);

        // R1..R5, R7, R8: streaming sweep with input gaps and output stalls
        idx = 0; inflight = 0; cyc = 0; prev_stall = 0; prev_res = '0;
        while (idx < N_ITEMS || exp_q.size() != 0) begin
            @(negedge clk);
            in_valid = (idx < N_ITEMS) && (cyc % 5 != 1);
            if (idx < N_ITEMS) begin
                a_word = st_a[idx]; b_word = st_b[idx]; addend = st_c[idx];
                a_signed = st_m[idx][0]; b_signed = st_m[idx][1]; half_sel = st_m[idx][2];
            end
            out_ready = (cyc % 7 != 3) && (cyc % 11 != 5) && (cyc % 13 != 6);
            #1;
            if (prev_stall) begin
                chk(out_valid, "R7 valid held while stalled", {31'b0, out_valid}, 32'd1);
                chk(result == prev_res, "R7 result held while stalled", result, prev_res);
            end
            chk(in_ready == !(inflight == 2 && !out_ready), "R8 in_ready vs occupancy",
                {31'b0, in_ready}, {31'b0, !(inflight == 2 && !out_ready)});
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7 unexpected extra result", result, 32'hx);
                end else begin
                    e = exp_q.pop_front();
                    chk(result == e, "R1/R2/R3/R4/R5 sweep result", result, e);
                end
                inflight--;
            end
            if (in_valid && in_ready) begin
                exp_q.push_back(st_e[idx]);
                idx++;
                inflight++;
            end
            prev_stall = out_valid && !out_ready;
            prev_res   = result;
            cyc++;
        end

        // R8 and R9: fill under backpressure, then reset mid-stream
        @(negedge clk);
        out_ready = 1'b0; in_valid = 1'b1;
        win = 0;
        repeat (4) begin
            #1;
            if (in_ready) win++;
            @(negedge clk);
        end
        #1;
        chk(win == 2, "R8 two sets accepted before blocking", 32'(win), 32'd2);
        chk(!in_ready, "R8 blocked when full and stalled", {31'b0, in_ready}, 32'd0);
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(!out_valid, "R9 reset empties a full pipeline", {31'b0, out_valid}, 32'd0);
        chk(in_ready, "R9 in_ready after mid-stream reset", {31'b0, in_ready}, 32'd1);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule